// File: doc/BRIEF.md
# Conversion Result Register File

This block stores the latest result of each analog channel as a 10-bit value. There are sixteen channels, so there are sixteen registers. A converter engine writes a result by channel number. Each such write also raises a done flag for that channel. The engine can mark a result as the final channel of a scan, and that makes the block emit a one-cycle interrupt request.

A processor on an 8/16-bit register bus can read any register as a word or as a byte. A word read returns the 10-bit value right-aligned. A byte read returns the eight most significant result bits, so software that needs only coarse resolution gets the useful bits in one byte.

Processor writes to register 0 are copied into every even-numbered register, and writes to register 1 into every odd-numbered register. This lets software preset a whole bank in one access. Writes to any other register touch only that register.

Top module: `adc_result_bank`

## Requirements
- R1: After reset every result register reads 0, all done flags are 0, `scan_irq` is 0 and `cpu_rvalid` is 0.
- R2: A byte read (`cpu_word`=0) returns result bits 9..2 in `cpu_rdata[7:0]`, with `cpu_rdata[15:8]` zero.
- R3: A word read (`cpu_word`=1) returns the 10-bit result in `cpu_rdata[9:0]`, with `cpu_rdata[15:10]` zero.
- R4: `cpu_rvalid` and `cpu_rdata` appear in the cycle after `cpu_rd` is sampled. The data is the register value before any write sampled on that same edge.
- R5: A processor write to address 0 stores the value in every even-numbered register.
- R6: A processor write to address 1 stores the value in every odd-numbered register.
- R7: A processor write to an address from 2 to 15 changes only that register.
- R8: A word write stores `cpu_wdata[9:0]`. A byte write stores `cpu_wdata[7:0]` into result bits 9..2 and keeps result bits 1..0.
- R9: A converter write (`cv_we`) stores `cv_data` into register `cv_ch` only, and sets `ch_done[cv_ch]` from the next cycle.
- R10: When the converter and the processor write the same register on the same edge, including through a broadcast, the converter value is kept. The other broadcast targets still take the processor value.
- R11: A processor read of a register clears that channel's done flag. A converter write to the same channel on the same edge leaves the flag set.
- R12: `scan_irq` is high for exactly the one cycle after a converter write with `cv_last`=1, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | Processor write strobe |
| cpu_word | input | 1 | Access size for read and write: 1 word, 0 byte |
| cpu_addr | input | 4 | Register index |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_rdata | output | 16 | Formatted read data |
| cpu_rvalid | output | 1 | Read data valid |
| cv_we | input | 1 | Converter result write strobe |
| cv_ch | input | 4 | Converter channel index |
| cv_data | input | 10 | Converter result |
| cv_last | input | 1 | Marks the last channel of a scan |
| ch_done | output | 16 | Per-channel result-ready flags |
| scan_irq | output | 1 | End-of-scan interrupt pulse |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. This covers read data and its valid, register contents after a write, done flags and the interrupt pulse. The driver applies a stimulus at the falling edge and computes the expected read word from its own model before applying that cycle's writes. The monitor pops the expected word at the falling edge where `cpu_rvalid` is high. Done flags and the interrupt are compared at the falling edge after the capturing rising edge, and the interrupt is compared again one cycle later to confirm it lasts a single cycle.

// File: rtl/adc_rf_pkg.sv
package adc_rf_pkg;

  localparam int BUS_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic {
    ACC_BYTE = 1'b0,
    ACC_WORD = 1'b1
  } acc_size_e;

endpackage

// File: rtl/adc_rf_wrdec.sv
module adc_rf_wrdec #(
  parameter int NCH = 16,
  parameter int AW  = 4
) (
  input  logic           cpu_we,
  input  logic [AW-1:0]  cpu_addr,
  input  logic           cv_we,
  input  logic [AW-1:0]  cv_ch,
  output logic [NCH-1:0] cpu_en,
  output logic [NCH-1:0] cv_en
);

  logic bcast_even;
  logic bcast_odd;

  always_comb begin
    bcast_even = cpu_we && (cpu_addr == AW'(0));
    bcast_odd  = cpu_we && (cpu_addr == AW'(1));
  end

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    localparam logic [AW-1:0] IDX    = AW'(i);
    localparam bit            IS_ODD = (i % 2) == 1;
    logic direct_hit;
    logic bcast_hit;

    always_comb begin
      direct_hit = cpu_we && (cpu_addr == IDX);
      bcast_hit  = IS_ODD ? bcast_odd : bcast_even;
      cpu_en[i]  = direct_hit || bcast_hit;
      cv_en[i]   = cv_we && (cv_ch == IDX);
    end
  end

endmodule

// File: rtl/adc_rf_cell.sv
module adc_rf_cell
  import adc_rf_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_en,
  input  logic             cpu_word,
  input  logic [RES_W-1:0] cpu_wdata,
  input  logic             cv_en,
  input  logic [RES_W-1:0] cv_data,
  output logic [RES_W-1:0] q
);

  localparam int LOW_W = RES_W - BYTE_W;

  logic [RES_W-1:0] byte_merge;
  logic [RES_W-1:0] q_nxt;
  logic             q_ce;

  if (LOW_W > 0) begin : g_merge_low
    always_comb byte_merge = {cpu_wdata[BYTE_W-1:0], q[LOW_W-1:0]};
  end else begin : g_merge_none
    always_comb byte_merge = cpu_wdata[BYTE_W-1 -: RES_W];
  end

  always_comb begin
    q_ce  = cv_en || cpu_en;
    q_nxt = q;
    if (cv_en) begin
      q_nxt = cv_data;
    end else if (cpu_en) begin
      q_nxt = (cpu_word == ACC_WORD) ? cpu_wdata : byte_merge;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (q_ce) begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/adc_rf_rdport.sv
module adc_rf_rdport
  import adc_rf_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int RES_W = 10,
  parameter int AW    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_rd,
  input  logic                 cpu_word,
  input  logic [AW-1:0]        cpu_addr,
  input  logic [NCH*RES_W-1:0] regs_flat,
  output logic [BUS_W-1:0]     rdata,
  output logic                 rvalid
);

  logic [RES_W-1:0] sel;
  logic [BUS_W-1:0] rdata_nxt;

  always_comb begin
    sel = regs_flat[int'(cpu_addr)*RES_W +: RES_W];
    if (cpu_word == ACC_WORD) begin
      rdata_nxt = BUS_W'(sel);
    end else begin
      rdata_nxt = BUS_W'(sel[RES_W-1 -: BYTE_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
    end else begin
      rvalid <= cpu_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (cpu_rd) begin
      rdata <= rdata_nxt;
    end
  end

endmodule

// File: rtl/adc_rf_flags.sv
module adc_rf_flags #(
  parameter int NCH = 16,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] cv_en,
  input  logic           cv_we,
  input  logic           cv_last,
  input  logic           cpu_rd,
  input  logic [AW-1:0]  cpu_addr,
  output logic [NCH-1:0] done,
  output logic           irq
);

  logic [NCH-1:0] rd_hit;
  logic [NCH-1:0] done_nxt;
  logic           irq_nxt;

  for (genvar i = 0; i < NCH; i++) begin : g_flag
    always_comb begin
      rd_hit[i]   = cpu_rd && (cpu_addr == AW'(i));
      done_nxt[i] = cv_en[i] || (done[i] && !rd_hit[i]);
    end
  end

  always_comb irq_nxt = cv_we && cv_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= '0;
      irq  <= 1'b0;
    end else begin
      done <= done_nxt;
      irq  <= irq_nxt;
    end
  end

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_rf_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int RES_W = 10,
  parameter int AW    = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_we,
  input  logic             cpu_word,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [15:0]      cpu_wdata,
  input  logic             cpu_rd,
  output logic [15:0]      cpu_rdata,
  output logic             cpu_rvalid,
  input  logic             cv_we,
  input  logic [AW-1:0]    cv_ch,
  input  logic [RES_W-1:0] cv_data,
  input  logic             cv_last,
  output logic [NCH-1:0]   ch_done,
  output logic             scan_irq
);

  logic [NCH-1:0]       cpu_en;
  logic [NCH-1:0]       cv_en;
  logic [NCH*RES_W-1:0] regs_flat;
  logic                 unused_wdata_hi;

  assign unused_wdata_hi = ^cpu_wdata[BUS_W-1:RES_W];

  adc_rf_wrdec #(.NCH(NCH), .AW(AW)) u_wrdec (
    .cpu_we   (cpu_we),
    .cpu_addr (cpu_addr),
    .cv_we    (cv_we),
    .cv_ch    (cv_ch),
    .cpu_en   (cpu_en),
    .cv_en    (cv_en)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_cell
    adc_rf_cell #(.RES_W(RES_W)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_en    (cpu_en[i]),
      .cpu_word  (cpu_word),
      .cpu_wdata (cpu_wdata[RES_W-1:0]),
      .cv_en     (cv_en[i]),
      .cv_data   (cv_data),
      .q         (regs_flat[i*RES_W +: RES_W])
    );
  end

  adc_rf_rdport #(.NCH(NCH), .RES_W(RES_W), .AW(AW)) u_rdport (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_rd    (cpu_rd),
    .cpu_word  (cpu_word),
    .cpu_addr  (cpu_addr),
    .regs_flat (regs_flat),
    .rdata     (cpu_rdata),
    .rvalid    (cpu_rvalid)
  );

  adc_rf_flags #(.NCH(NCH), .AW(AW)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .cv_en    (cv_en),
    .cv_we    (cv_we),
    .cv_last  (cv_last),
    .cpu_rd   (cpu_rd),
    .cpu_addr (cpu_addr),
    .done     (ch_done),
    .irq      (scan_irq)
  );

endmodule

// File: rtl/adc_result_bank_chk.sv
module adc_result_bank_chk #(
  parameter int NCH   = 16,
  parameter int RES_W = 10,
  parameter int AW    = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cpu_rd,
  input logic           cpu_word,
  input logic [AW-1:0]  cpu_addr,
  input logic           cv_we,
  input logic [AW-1:0]  cv_ch,
  input logic           cv_last,
  input logic [15:0]    cpu_rdata,
  input logic           cpu_rvalid,
  input logic [NCH-1:0] ch_done,
  input logic           scan_irq
);

  // R4: valid follows the read strobe by one cycle
  a_r4_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd |=> cpu_rvalid);
  a_r4_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |=> !cpu_rvalid);

  // R2: byte reads leave the upper byte clear
  a_r2_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !cpu_word) |=> (cpu_rdata[15:8] == 8'h00));

  // R3: word reads leave bits above the result clear
  a_r3_word_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_word) |=> (cpu_rdata[15:RES_W] == '0));

  // R9: converter write raises the channel's done flag
  a_r9_done_set: assert property (@(posedge clk) disable iff (!rst_n)
    cv_we |=> ch_done[$past(cv_ch)]);

  // R11: a read without a colliding converter write clears the flag
  a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !(cv_we && (cv_ch == cpu_addr))) |=> !ch_done[$past(cpu_addr)]);

  // R12: interrupt pulses only after a last-channel write
  a_r12_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_we && cv_last) |=> scan_irq);
  a_r12_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(cv_we && cv_last) |=> !scan_irq);

endmodule

bind adc_result_bank adc_result_bank_chk #(.NCH(NCH), .RES_W(RES_W), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_rd     (cpu_rd),
  .cpu_word   (cpu_word),
  .cpu_addr   (cpu_addr),
  .cv_we      (cv_we),
  .cv_ch      (cv_ch),
  .cv_last    (cv_last),
  .cpu_rdata  (cpu_rdata),
  .cpu_rvalid (cpu_rvalid),
  .ch_done    (ch_done),
  .scan_irq   (scan_irq)
);

// File: tb/adc_result_bank_tb.sv
module adc_result_bank_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;
  localparam int RW  = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_we = 1'b0, cpu_word = 1'b0, cpu_rd = 1'b0;
  logic [3:0]    cpu_addr = '0;
  logic [15:0]   cpu_wdata = '0;
  logic [15:0]   cpu_rdata;
  logic          cpu_rvalid;
  logic          cv_we = 1'b0, cv_last = 1'b0;
  logic [3:0]    cv_ch = '0;
  logic [RW-1:0] cv_data = '0;
  logic [NCH-1:0] ch_done;
  logic          scan_irq;

  int n_checks = 0;
  int n_fail   = 0;

  logic [RW-1:0] mdl [NCH];
  logic          mdone [NCH];
  logic [15:0]   exp_q [$];
  string         tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_result_bank u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_word(cpu_word),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd),
    .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid), .cv_we(cv_we),
    .cv_ch(cv_ch), .cv_data(cv_data), .cv_last(cv_last),
    .ch_done(ch_done), .scan_irq(scan_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected word per valid read
  always @(negedge clk) begin
    if (rst_n && cpu_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R4 unexpected rvalid", 32'd1, 32'd0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {16'h0, cpu_rdata}, {16'h0, e});
      end
    end
  end

  // one bus cycle; read expectation taken before this cycle's writes
  task automatic cyc(input bit rd, input bit rd_word, input int rd_addr,
                     input bit we, input bit w_word, input int w_addr, input logic [15:0] wd,
                     input bit cv, input int ch, input logic [RW-1:0] cd, input bit last,
                     input string tag);
    logic [RW-1:0] cur;
    cpu_rd = rd; cpu_we = we; cv_we = cv; cv_last = last;
    cpu_word = rd ? rd_word : w_word;
    cpu_addr = 4'(rd ? rd_addr : w_addr);
    cpu_wdata = wd; cv_ch = 4'(ch); cv_data = cd;
    if (rd) begin
      cur = mdl[rd_addr];
      exp_q.push_back(rd_word ? {6'h0, cur} : {8'h0, cur[9:2]});
      tag_q.push_back(tag);
      mdone[rd_addr] = 1'b0;
    end
    if (we) begin
      for (int j = 0; j < NCH; j++) begin
        if (j == w_addr || (w_addr == 0 && j % 2 == 0) || (w_addr == 1 && j % 2 == 1))
          mdl[j] = w_word ? wd[9:0] : {wd[7:0], mdl[j][1:0]};
      end
    end
    if (cv) begin
      mdl[ch] = cd;
      mdone[ch] = 1'b1;
    end
    @(negedge clk);
    cpu_rd = 0; cpu_we = 0; cv_we = 0; cv_last = 0;
  endtask

  task automatic wr(input bit word, input int a, input logic [15:0] d);
    cyc(0, 0, 0, 1, word, a, d, 0, 0, '0, 0, "");
  endtask

  task automatic rd(input bit word, input int a, input string tag);
    cyc(1, word, a, 0, 0, 0, '0, 0, 0, '0, 0, tag);
  endtask

  task automatic conv(input int ch, input logic [RW-1:0] d, input bit last);
    cyc(0, 0, 0, 0, 0, 0, '0, 1, ch, d, last, "");
  endtask

  task automatic read_all(input string tag);
    for (int k = 0; k < NCH; k++) rd(1, k, tag);
    @(negedge clk);
  endtask

  task automatic check_done(input string tag);
    logic [NCH-1:0] e;
    for (int k = 0; k < NCH; k++) e[k] = mdone[k];
    check(tag, {16'h0, ch_done}, {16'h0, e});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog", 32'd1, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < NCH; k++) begin mdl[k] = '0; mdone[k] = 1'b0; end
    repeat (3) @(negedge clk);
    check("R1 rvalid in reset", {31'h0, cpu_rvalid}, 32'd0);
    check("R1 irq in reset", {31'h0, scan_irq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_done("R1 done after reset");
    read_all("R1 register after reset");

    // R7: single register write
    wr(1, 5, 16'hF2AB);
    read_all("R7 single write");

    // R5: even broadcast
    wr(1, 0, 16'h0155);
    read_all("R5 even broadcast");

    // R6: odd broadcast
    wr(1, 1, 16'h03C3);
    read_all("R6 odd broadcast");

    // R8 and R2: byte write keeps low bits, byte read returns top bits
    wr(0, 6, 16'h77A5);
    rd(1, 6, "R8 byte write merge");
    rd(0, 6, "R2 byte read");
    rd(0, 3, "R2 byte read odd");
    wr(0, 1, 16'h005A);
    read_all("R8 byte broadcast");

    // R9: converter write, done flag, no irq
    conv(9, 10'h0F0, 0);
    check_done("R9 done set");
    check("R12 no irq without last", {31'h0, scan_irq}, 32'd0);
    read_all("R9 converter value");
    check_done("R11 done cleared by read");

    // R10: converter wins on collision with broadcast
    cyc(0, 0, 0, 1, 1, 0, 16'h0222, 1, 2, 10'h111, 0, "");
    read_all("R10 converter priority");

    // R12: last channel interrupt pulse
    conv(15, 10'h3FF, 1);
    check("R12 irq pulse", {31'h0, scan_irq}, 32'd1);
    @(negedge clk);
    check("R12 irq single cycle", {31'h0, scan_irq}, 32'd0);

    // R4: read and write on the same edge returns old value
    cyc(1, 1, 7, 1, 1, 7, 16'h0099, 0, 0, '0, 0, "R4 read before write");
    rd(1, 7, "R4 new value");

    // R11: read colliding with converter write keeps done set
    cyc(1, 1, 4, 0, 0, 0, '0, 1, 4, 10'h2C1, 0, "R11 collide read");
    check_done("R11 set wins");
    rd(1, 4, "R11 value after collide");
    @(negedge clk);
    check_done("R11 cleared later");

    repeat (3) @(negedge clk);
    check("R4 queue drained", exp_q.size(), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule